// File: doc/BRIEF.md
# Transport Stream Output Formatter

This block sits at the end of a receive chain and turns the byte stream coming out of the error-correction stages into transport frames of 188 bytes. The byte source delivers data in bursts with stalls between them. Every accepted byte passes through an internal FIFO. An output scheduler then sends it out either as a whole byte per output strobe or as single bits, most significant bit first, on bit 0 of the output bus.

Two run-time switches choose how stalls are handled. In gapped operation a byte leaves as soon as it is available, so the source's stalls show up on the output. In gap-free operation a frame starts only once the FIFO holds a whole frame, so its bytes leave back to back. With framing enabled, the block looks for the 0x47 sync byte at each frame start, marks that byte with a frame-sync flag and discards bytes that cannot start a frame. With framing disabled, every byte passes through unmarked for cell-based traffic. The output is qualified by a strobe rather than a gated clock. Configuration inputs are expected to change only while reset is held.

Top module: `tsfmt_top`

## Requirements
- R1: After a synchronous reset, out_strobe, out_fsync and out_data are all zero and in_ready is high.
- R2: In parallel gapped mode, a byte accepted at a rising edge (in_valid and in_ready both high) appears on out_data, with out_strobe high for one cycle, at the second rising edge after that edge. Bytes leave in the order they were accepted, with none lost or repeated.
- R3: In serial mode (cfg_serial=1), each byte occupies 8 consecutive strobed cycles. The bits appear on out_data[0], most significant bit first, and out_data[7:1] is zero.
- R4: In gapped mode (cfg_gapfree=0), stalls of the source appear as cycles without a strobe inside a frame.
- R5: In gap-free mode (cfg_gapfree=1), no byte of a frame is emitted until the FIFO holds 188 bytes. Once a frame starts, its 188 bytes (parallel) or 1504 bits (serial) leave on consecutive cycles.
- R6: With framing enabled (cfg_frame_en=1), out_fsync is high exactly during the first byte (parallel) or the first bit (serial) of each frame, and that byte is 0x47. The next frame starts 188 emitted bytes later.
- R7: With framing enabled, a byte other than 0x47 that reaches the frame-start position is discarded and never appears on the output.
- R8: With framing disabled, every accepted byte is emitted, whatever its value, and out_fsync stays low.
- R9: in_ready is low while the FIFO holds 256 bytes. No byte is lost or overwritten when the output drains more slowly than the source.
- R10: out_data is zero in every cycle in which out_strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_serial | input | 1 | 1 = one bit per strobe, 0 = one byte per strobe |
| cfg_gapfree | input | 1 | 1 = emit whole frames back to back from the FIFO |
| cfg_frame_en | input | 1 | 1 = sync-byte framing and frame-sync flag enabled |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | FIFO can accept a byte this cycle |
| out_data | output | 8 | Output byte, or output bit on bit 0 in serial mode |
| out_strobe | output | 1 | Output position valid this cycle |
| out_fsync | output | 1 | First byte or bit of a frame |

## Verification
A wrong FIFO pointer or visibility lag shows at the ports within a few cycles as a repeated, missing or reordered byte. The bench compares every emitted byte with its own model of the stream. A drifting frame-position counter puts out_fsync on a byte other than 0x47, or lets a non-sync byte through, by the end of the first frame. A bad gap-free start threshold shows up as strobe-free cycles inside a frame, or as output before the 188th byte has arrived. Serial-shifter faults corrupt bit order or upper-bit zeroing on the very first byte.

// File: rtl/tsfmt_pkg.sv
package tsfmt_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] MPEG_SYNC = 8'h47;

  typedef struct packed {
    logic serial;
    logic gapfree;
    logic frame_en;
  } tsfmt_cfg_t;
endpackage

// File: rtl/tsfmt_fifo.sv
module tsfmt_fifo #(
  parameter int AW = 8,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  head,
  output logic [AW:0]   avail,
  output logic          not_full
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);
  localparam logic [AW:0] ONE_C   = (AW+1)'(1);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr, rd_ptr, wr_vis, rd_nxt, used;

  assign rd_nxt   = rd_en ? rd_ptr + ONE_C : rd_ptr;
  assign used     = wr_ptr - rd_ptr;
  assign not_full = (used != DEPTH_C);
  // entries become visible one cycle after the write so the registered read sees them
  assign avail    = wr_vis - rd_ptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_data;
    head <= mem[rd_nxt[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      wr_vis <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + ONE_C;
      rd_ptr <= rd_nxt;
      wr_vis <= wr_ptr;
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    used <= DEPTH_C);
  assert_pop_has_data_R2: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> avail != '0);
endmodule

// File: rtl/tsfmt_sched.sv
module tsfmt_sched #(
  parameter int              AW        = 8,
  parameter int              W         = 8,
  parameter int              FRAME_LEN = 188,
  parameter logic [W-1:0]    SYNC_BYTE = 8'h47
) (
  input  logic                 clk,
  input  logic                 rst,
  input  tsfmt_pkg::tsfmt_cfg_t cfg,
  input  logic [AW:0]          avail,
  input  logic [W-1:0]         head,
  input  logic                 slot_free,
  output logic                 pop,
  output logic                 emit,
  output logic                 first
);
  localparam int PW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam logic [PW-1:0] LAST_POS = PW'(FRAME_LEN - 1);
  localparam logic [AW:0]   FL_CNT   = (AW+1)'(FRAME_LEN);

  logic [PW-1:0] pos;
  logic at_start, have, drop;

  assign at_start = (pos == '0);
  assign have     = (avail != '0);
  assign first    = at_start;
  assign pop      = emit | drop;

  always_comb begin
    emit = 1'b0;
    drop = 1'b0;
    if (slot_free && have) begin
      if (!at_start)                           emit = 1'b1;
      else if (cfg.frame_en && head != SYNC_BYTE) drop = 1'b1;
      else if (!cfg.gapfree || avail >= FL_CNT)   emit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       pos <= '0;
    else if (emit) pos <= (pos == LAST_POS) ? '0 : pos + PW'(1);
  end

  assert_gapfree_no_underrun_R5: assert property (@(posedge clk) disable iff (rst)
    cfg.gapfree && !at_start |-> have);
  assert_pos_in_frame_R6: assert property (@(posedge clk) disable iff (rst)
    pos <= LAST_POS);
endmodule

// File: rtl/tsfmt_emit.sv
module tsfmt_emit #(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          serial,
  input  logic          frame_en,
  input  logic          load,
  input  logic          first,
  input  logic [W-1:0]  head,
  output logic          slot_free,
  output logic [W-1:0]  out_data,
  output logic          out_strobe,
  output logic          out_fsync
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);

  logic [W-1:0]  sh;
  logic [CW-1:0] bits_left;

  assign slot_free = !serial || (bits_left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh         <= '0;
      bits_left  <= '0;
      out_data   <= '0;
      out_strobe <= 1'b0;
      out_fsync  <= 1'b0;
    end else if (load) begin
      out_strobe <= 1'b1;
      out_fsync  <= first && frame_en;
      if (serial) begin
        out_data  <= {{(W-1){1'b0}}, head[W-1]};
        sh        <= {head[W-2:0], 1'b0};
        bits_left <= LAST_BIT;
      end else begin
        out_data  <= head;
        bits_left <= '0;
      end
    end else if (serial && bits_left != '0) begin
      out_strobe <= 1'b1;
      out_fsync  <= 1'b0;
      out_data   <= {{(W-1){1'b0}}, sh[W-1]};
      sh         <= {sh[W-2:0], 1'b0};
      bits_left  <= bits_left - CW'(1);
    end else begin
      out_strobe <= 1'b0;
      out_fsync  <= 1'b0;
      out_data   <= '0;
    end
  end

  assert_serial_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    $past(serial) && out_strobe |-> out_data[W-1:1] == '0);
  assert_serial_fsync_one_bit_R6: assert property (@(posedge clk) disable iff (rst)
    serial && out_fsync |=> out_strobe && !out_fsync);
  assert_no_load_while_busy_R3: assert property (@(posedge clk) disable iff (rst)
    serial && bits_left != '0 |-> !load);
endmodule

// File: rtl/tsfmt_top.sv
module tsfmt_top #(
  parameter int   FRAME_LEN = 188,
  parameter int   FIFO_AW   = 8,
  parameter logic [7:0] SYNC_BYTE = tsfmt_pkg::MPEG_SYNC
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_serial,
  input  logic       cfg_gapfree,
  input  logic       cfg_frame_en,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic [7:0] out_data,
  output logic       out_strobe,
  output logic       out_fsync
);
  localparam int W = tsfmt_pkg::BYTE_W;

  tsfmt_pkg::tsfmt_cfg_t cfg;
  logic [W-1:0]    head;
  logic [FIFO_AW:0] avail;
  logic not_full, wr_en, pop, emit, first, slot_free;

  assign cfg      = '{serial: cfg_serial, gapfree: cfg_gapfree, frame_en: cfg_frame_en};
  assign in_ready = not_full;
  assign wr_en    = in_valid && not_full;

  tsfmt_fifo #(.AW(FIFO_AW), .W(W)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(in_data), .rd_en(pop),
    .head(head), .avail(avail), .not_full(not_full)
  );

  tsfmt_sched #(.AW(FIFO_AW), .W(W), .FRAME_LEN(FRAME_LEN), .SYNC_BYTE(SYNC_BYTE)) u_sched (
    .clk(clk), .rst(rst), .cfg(cfg), .avail(avail), .head(head),
    .slot_free(slot_free), .pop(pop), .emit(emit), .first(first)
  );

  tsfmt_emit #(.W(W)) u_emit (
    .clk(clk), .rst(rst), .serial(cfg.serial), .frame_en(cfg.frame_en),
    .load(emit), .first(first), .head(head), .slot_free(slot_free),
    .out_data(out_data), .out_strobe(out_strobe), .out_fsync(out_fsync)
  );

  assert_fsync_on_sync_byte_R6: assert property (@(posedge clk) disable iff (rst)
    $past(!cfg_serial) && out_fsync |-> out_data == SYNC_BYTE);
  assert_bypass_no_fsync_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!cfg_frame_en) |-> !out_fsync);
  assert_fsync_needs_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    out_fsync |-> out_strobe);
endmodule

// File: tb/tsfmt_top_bench.sv
module tsfmt_top_bench;
  localparam int FL = 188;
  localparam int NCASE = 8;
  localparam int MAXB = 600;
  // columns: serial, gapfree, frame_en, frames, junk, gap, exp_fsync, exp_midgap(2=any), exp_ready_low(2=any)
  localparam int TBL [NCASE][9] = '{
    '{0,0,1,2,0,2, 2,1,0},
    '{0,1,1,2,0,2, 2,0,2},
    '{1,0,1,1,0,1, 1,2,2},
    '{1,1,1,1,0,0, 1,0,2},
    '{0,0,1,1,3,1, 1,1,0},
    '{0,0,0,1,3,0, 0,2,0},
    '{0,1,0,1,0,3, 0,0,2},
    '{1,0,0,2,0,0, 0,2,1}
  };

  logic clk = 0, rst = 1;
  logic cfg_serial = 0, cfg_gapfree = 0, cfg_frame_en = 0;
  logic in_valid = 0;
  logic [7:0] in_data = 0;
  logic in_ready, out_strobe, out_fsync;
  logic [7:0] out_data;

  tsfmt_top u_tsfmt_top (
    .clk(clk), .rst(rst), .cfg_serial(cfg_serial), .cfg_gapfree(cfg_gapfree),
    .cfg_frame_en(cfg_frame_en), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_data(out_data), .out_strobe(out_strobe), .out_fsync(out_fsync)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] in_b [MAXB];
  logic [7:0] exp_b [MAXB];
  int n_in, exp_cnt;
  bit mon_en = 0;
  int rx_cnt, bitph, mism, fs_cnt, fs_bad, midgap, upper_bad, idle_bad;
  logic [7:0] acc;
  bit ready_low;

  task automatic check(input bit ok, input string req, input int act, input int expv, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (mon_en && !rst) begin
      if (!out_strobe) begin
        if (out_data != 0) idle_bad++;
        if (out_fsync) fs_bad++;
        if (rx_cnt > 0 && rx_cnt < exp_cnt && ((rx_cnt % FL) != 0 || bitph != 0)) midgap++;
      end else if (!cfg_serial) begin
        if (out_fsync) fs_cnt++;
        if (out_fsync != (cfg_frame_en && (rx_cnt % FL) == 0)) fs_bad++;
        if (rx_cnt >= exp_cnt || out_data != exp_b[rx_cnt]) mism++;
        rx_cnt++;
      end else begin
        if (out_data[7:1] != 0) upper_bad++;
        if (out_fsync) fs_cnt++;
        if (bitph == 0) begin
          if (out_fsync != (cfg_frame_en && (rx_cnt % FL) == 0)) fs_bad++;
        end else if (out_fsync) fs_bad++;
        acc = {acc[6:0], out_data[0]};
        bitph++;
        if (bitph == 8) begin
          if (rx_cnt >= exp_cnt || acc != exp_b[rx_cnt]) mism++;
          rx_cnt++;
          bitph = 0;
        end
      end
    end
  end

  task automatic mon_clear();
    rx_cnt = 0; bitph = 0; mism = 0; fs_cnt = 0; fs_bad = 0; midgap = 0;
    upper_bad = 0; idle_bad = 0; acc = 0; ready_low = 0;
  endtask

  task automatic do_reset(input bit ser, input bit gf, input bit fen);
    mon_en = 0;
    rst = 1; in_valid = 0;
    cfg_serial = ser; cfg_gapfree = gf; cfg_frame_en = fen;
    repeat (3) @(negedge clk);
    rst = 0;
    mon_clear();
    @(negedge clk);
  endtask

  // builds stimulus and expected stream; framing model drops non-sync bytes at frame start
  task automatic build(input int frames, input int junk, input bit fen);
    int pos = 0;
    n_in = 0; exp_cnt = 0;
    for (int j = 0; j < junk; j++) begin in_b[n_in] = 8'h10 + 8'(j); n_in++; end
    for (int f = 0; f < frames; f++)
      for (int k = 0; k < FL; k++) begin
        in_b[n_in] = (k == 0) ? 8'h47 : 8'((k * 13 + f * 7 + 1) & 255);
        n_in++;
      end
    for (int i = 0; i < n_in; i++) begin
      if (fen && pos == 0 && in_b[i] != 8'h47) continue;
      exp_b[exp_cnt] = in_b[i]; exp_cnt++;
      pos = (pos + 1) % FL;
    end
  endtask

  task automatic send(input int from, input int to, input int gap);
    for (int i = from; i < to; i++) begin
      while (!in_ready) begin ready_low = 1; @(negedge clk); end
      in_valid = 1; in_data = in_b[i];
      @(negedge clk);
      in_valid = 0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic drain();
    int t = 0;
    while (!(rx_cnt >= exp_cnt && bitph == 0) && t < 20000) begin @(negedge clk); t++; end
    repeat (20) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    do_reset(0, 0, 0);
    check(out_strobe == 0, "R1", out_strobe, 0, "strobe after reset");
    check(out_fsync == 0, "R1", out_fsync, 0, "fsync after reset");
    check(out_data == 0, "R1", out_data, 0, "data after reset");
    check(in_ready == 1, "R1", in_ready, 1, "ready after reset");

    // table-driven cases
    for (int c = 0; c < NCASE; c++) begin
      do_reset(TBL[c][0] != 0, TBL[c][1] != 0, TBL[c][2] != 0);
      build(TBL[c][3], TBL[c][4], TBL[c][2] != 0);
      mon_en = 1;
      send(0, n_in, TBL[c][5]);
      drain();
      check(rx_cnt == exp_cnt, "R2 R7 R8", rx_cnt, exp_cnt, $sformatf("case %0d byte count", c));
      check(mism == 0, "R2 R3", mism, 0, $sformatf("case %0d byte mismatches", c));
      check(fs_cnt == TBL[c][6], "R6 R8", fs_cnt, TBL[c][6], $sformatf("case %0d fsync count", c));
      check(fs_bad == 0, "R6", fs_bad, 0, $sformatf("case %0d misplaced fsync", c));
      check(idle_bad == 0, "R10", idle_bad, 0, $sformatf("case %0d nonzero idle data", c));
      if (TBL[c][0] != 0)
        check(upper_bad == 0, "R3", upper_bad, 0, $sformatf("case %0d serial upper bits", c));
      if (TBL[c][7] == 0)
        check(midgap == 0, "R5", midgap, 0, $sformatf("case %0d gaps inside frame", c));
      else if (TBL[c][7] == 1)
        check(midgap > 0, "R4", midgap, 1, $sformatf("case %0d gaps inside frame", c));
      if (TBL[c][8] != 2)
        check(int'(ready_low) == TBL[c][8], "R9", ready_low, TBL[c][8], $sformatf("case %0d ready low seen", c));
    end

    // R2: exact latency in parallel gapped mode
    do_reset(0, 0, 0);
    in_valid = 1; in_data = 8'hA5;
    @(negedge clk); in_valid = 0;
    check(out_strobe == 0, "R2", out_strobe, 0, "strobe one edge after accept");
    @(negedge clk);
    check(out_strobe == 0, "R2", out_strobe, 0, "strobe at first edge after accept");
    @(negedge clk);
    check(out_strobe == 1 && out_data == 8'hA5, "R2", out_data, 8'hA5, "byte at second edge after accept");
    @(negedge clk);
    check(out_strobe == 0 && out_data == 0, "R10", out_data, 0, "idle after single byte");

    // R5: gap-free holds a partial frame
    do_reset(0, 1, 1);
    build(1, 0, 1);
    mon_en = 1;
    send(0, FL - 1, 0);
    repeat (30) @(negedge clk);
    check(rx_cnt == 0, "R5", rx_cnt, 0, "bytes out before full frame");
    send(FL - 1, FL, 0);
    drain();
    check(rx_cnt == FL, "R5", rx_cnt, FL, "bytes out after full frame");
    check(midgap == 0, "R5", midgap, 0, "gaps inside gap-free frame");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule